// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog Reset

This block is the system tick source for an operating system. One free-running up-counter advances on every clock cycle in which the `tick_en` strobe is high. Four match registers are each compared against the value the counter is about to take. When the counter steps onto a match value, that channel raises a status flag and its own interrupt line, but only if software has enabled interrupts for that channel. Software acknowledges an interrupt by writing a one to the status bit.

The highest channel can also act as a watchdog. Software arms it by setting one bit. If the channel then matches before software moves its match value further ahead, the block issues a one-cycle system reset request and disarms itself. Software reaches all state through a simple word-addressed read/write port. Read data is registered, and accesses to holes in the map raise a one-cycle error flag.

Top module: `os_match_timer`

## Requirements
- R1: After reset, every mapped register reads zero, `irq` is all zeros and `rst_req` is low.
- R2: The counter (word offset 0x10) increments by one at each clock edge where `tick_en` is high. A write to 0x10 loads the written value, overrides a tick in the same cycle, and counting then continues from the loaded value.
- R3: The counter is 32 bits wide and wraps from 0xFFFFFFFF to 0 on a tick.
- R4: When a tick moves the counter onto the value of match register n (offset 4*n) and bit n of the interrupt enable register (0x1C) is set, status bit n (register 0x14, bit n) and `irq[n]` become 1 at the same clock edge, and they stay 1 until cleared.
- R5: A match on a channel whose enable bit is clear changes neither its status bit nor its `irq` line.
- R6: Only a tick can produce a match. Loading the counter directly with a match value sets no status bit.
- R7: A write to 0x14 clears each status bit written as 1 and drops its `irq` line. Bits written as 0 are kept. A match that sets a bit in the same cycle as its clear wins, and the bit stays 1.
- R8: The interrupt enable register stores only the low 12 bits of the written data and reads the upper bits as zero.
- R9: When bit 0 of the watchdog register (0x18) is 1 and channel 3 matches, `rst_req` is high for exactly one cycle, at the same edge as the match, and bit 0 is cleared. This happens whatever the interrupt enables are. Once disarmed, a later match on channel 3 gives no request.
- R10: An access to an offset outside 0x00–0x1C, or one with `addr[1:0]` not zero, returns zero on a read and changes nothing on a write. `err` is 1 in the cycle after such an access and 0 after a mapped access or no access.
- R11: Read data appears on `rdata` in the cycle after `rd_en` and is zero in other cycles. The match registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter advance strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Unmapped-access flag, one cycle after the access |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four channels, a 12-bit enable register and an 8-bit offset. With these values, loading the counter just below 2^32 puts the wrap-around within a few ticks. The full 0x00–0x1C map is then present, so every hole and every misaligned offset can be probed. Match values are written only a few counts ahead of the counter, so that random ticking produces frequent matches. These matches fall alongside status clears, counter loads and watchdog arming, which brings the set-against-clear and disarm orderings within reach.

// File: rtl/tmr_pkg.sv
// Shared decode types for the match-compare timer.
// Assumes word-aligned offsets; word indices below fix the register map.
package tmr_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_CNT,
        SEL_STS,
        SEL_WDE,
        SEL_IEN
    } sel_e;

    localparam int WORD_CNT = 4;
    localparam int WORD_STS = 5;
    localparam int WORD_WDE = 6;
    localparam int WORD_IEN = 7;
endpackage

// File: rtl/tmr_counter.sv
// Free-running up-counter with a software load port.
// Assumes a load in the same cycle as a tick takes priority over the tick.
module tmr_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_inc,
    output logic          adv
);
    // value the counter takes on a tick; wraps naturally
    assign cnt_inc = cnt + CW'(1);
    // a real advance happens only when no load competes
    assign adv     = tick & ~load;

    // counter register: load, advance or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt_inc;
        end
    end
endmodule

// File: rtl/tmr_chan.sv
// One compare channel: match register, equality detect, sticky status bit.
// Assumes the compare sees the counter's next value so that status rises
// on the same edge the counter lands on the match value.
module tmr_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_match,
    input  logic [CW-1:0] wdata,
    input  logic          adv,
    input  logic [CW-1:0] cnt_inc,
    input  logic          ien_bit,
    input  logic          clr_bit,
    output logic [CW-1:0] match_val,
    output logic          hit,
    output logic          sts
);
    // event: a genuine tick stepping onto the stored value
    assign hit = adv && (cnt_inc == match_val);

    // match register write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_val <= '0;
        end else if (wr_match) begin
            match_val <= wdata;
        end
    end

    // sticky status: an enabled event wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (hit && ien_bit) begin
            sts <= 1'b1;
        end else if (clr_bit) begin
            sts <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_regif.sv
// Register decode and registered read path.
// Assumes at most four channels so match words fit below the counter word.
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int CW    = 32,
    parameter int NCH   = 4,
    parameter int IEN_W = 12,
    parameter int AW    = 8,
    parameter int IW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     cnt,
    input  logic [NCH*CW-1:0] match_flat,
    input  logic [NCH-1:0]    sts,
    input  logic              wde,
    input  logic [IEN_W-1:0]  ien,
    output sel_e              sel,
    output logic [IW-1:0]     midx,
    output logic [CW-1:0]     rdata,
    output logic              err
);
    localparam int WW = AW - 2;

    logic [WW-1:0] word;
    logic [CW-1:0] rd_val;

    assign word = addr[AW-1:2];

    // map an offset to a register selector; misaligned offsets map nowhere
    always_comb begin
        sel  = SEL_NONE;
        midx = '0;
        if (addr[1:0] == 2'b00) begin
            if (word < WW'(NCH)) begin
                sel  = SEL_MATCH;
                midx = word[IW-1:0];
            end else if (word == WW'(WORD_CNT)) begin
                sel = SEL_CNT;
            end else if (word == WW'(WORD_STS)) begin
                sel = SEL_STS;
            end else if (word == WW'(WORD_WDE)) begin
                sel = SEL_WDE;
            end else if (word == WW'(WORD_IEN)) begin
                sel = SEL_IEN;
            end
        end
    end

    // readback multiplexer
    always_comb begin
        case (sel)
            SEL_MATCH: rd_val = match_flat[midx*CW +: CW];
            SEL_CNT:   rd_val = cnt;
            SEL_STS:   rd_val = CW'(sts);
            SEL_WDE:   rd_val = CW'(wde);
            SEL_IEN:   rd_val = CW'(ien);
            default:   rd_val = '0;
        endcase
    end

    // registered read data and hole-access flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_en ? rd_val : '0;
            err   <= (rd_en || wr_en) && (sel == SEL_NONE);
        end
    end
endmodule

// File: rtl/os_match_timer.sv
// Operating-system timer top: counter, compare channels, enables, status,
// and a watchdog that turns the last channel's match into a reset request.
// Assumes NCH <= 4 and NCH <= IEN_W; the bus issues reads and writes singly.
module os_match_timer
    import tmr_pkg::*;
#(
    parameter int CW    = 32,
    parameter int NCH   = 4,
    parameter int IEN_W = 12,
    parameter int AW    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rdata,
    output logic           err,
    output logic [NCH-1:0] irq,
    output logic           rst_req
);
    localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WD_CH = NCH - 1;

    sel_e              sel;
    logic [IW-1:0]     midx;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_inc;
    logic              adv;
    logic [NCH*CW-1:0] match_flat;
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    sts;
    logic [IEN_W-1:0]  ien_q;
    logic              wde_q;
    logic              rq_q;
    logic              cnt_wr;
    logic              sts_wr;

    assign cnt_wr = wr_en && (sel == SEL_CNT);
    assign sts_wr = wr_en && (sel == SEL_STS);

    tmr_regif #(
        .CW(CW), .NCH(NCH), .IEN_W(IEN_W), .AW(AW), .IW(IW)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .cnt        (cnt_q),
        .match_flat (match_flat),
        .sts        (sts),
        .wde        (wde_q),
        .ien        (ien_q),
        .sel        (sel),
        .midx       (midx),
        .rdata      (rdata),
        .err        (err)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .load     (cnt_wr),
        .load_val (wdata),
        .cnt      (cnt_q),
        .cnt_inc  (cnt_inc),
        .adv      (adv)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        logic wr_m;
        assign wr_m = wr_en && (sel == SEL_MATCH) && (midx == IW'(n));

        tmr_chan #(.CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_match  (wr_m),
            .wdata     (wdata),
            .adv       (adv),
            .cnt_inc   (cnt_inc),
            .ien_bit   (ien_q[n]),
            .clr_bit   (sts_wr && wdata[n]),
            .match_val (match_flat[n*CW +: CW]),
            .hit       (hit[n]),
            .sts       (sts[n])
        );
    end

    // interrupt enable register, truncated to its implemented width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_en && (sel == SEL_IEN)) begin
            ien_q <= wdata[IEN_W-1:0];
        end
    end

    // watchdog arm bit and one-shot reset request; a firing disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wde_q <= 1'b0;
            rq_q  <= 1'b0;
        end else begin
            rq_q <= hit[WD_CH] && wde_q;
            if (hit[WD_CH] && wde_q) begin
                wde_q <= 1'b0;
            end else if (wr_en && (sel == SEL_WDE)) begin
                wde_q <= wdata[0];
            end
        end
    end

    assign irq     = sts;
    assign rst_req = rq_q;
endmodule

// File: rtl/tmr_chk.sv
// Temporal checks for the match-compare timer, bound to the top module.
// Assumes synchronous active-low reset; each check waits one cycle past it.
module tmr_chk #(
    parameter int CW  = 32,
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           wr_en,
    input logic           rd_en,
    input logic [AW-1:0]  addr,
    input logic [CW-1:0]  cnt,
    input logic [NCH-1:0] ien,
    input logic           wde,
    input logic [NCH-1:0] irq,
    input logic           rst_req,
    input logic           err
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_en) && !$past(wr_en && (addr == AW'(16))))
        |-> (cnt == $past(cnt) + CW'(1)));

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((irq & ~$past(irq) & ~$past(ien)) == '0));

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((~irq & $past(irq)) != '0))
        |-> $past(wr_en && (addr == AW'(20))));

    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    wde_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !wde);

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err) |-> $past(wr_en || rd_en));
endmodule

bind os_match_timer tmr_chk #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .cnt     (cnt_q),
    .ien     (ien_q[NCH-1:0]),
    .wde     (wde_q),
    .irq     (irq),
    .rst_req (rst_req),
    .err     (err)
);

// File: tb/os_match_timer_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a register-level model built from the requirements.
module os_match_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW    = 32;
    localparam int NCH   = 4;
    localparam int IEN_W = 12;
    localparam int AW    = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [CW-1:0]  wdata = '0;
    logic [CW-1:0]  rdata;
    logic           err;
    logic [NCH-1:0] irq;
    logic           rst_req;

    os_match_timer #(.CW(CW), .NCH(NCH), .IEN_W(IEN_W), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .err(err), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt;
    logic [31:0] m_match [NCH];
    logic [11:0] m_ien;
    logic [3:0]  m_sts;
    logic        m_wde;

    function automatic bit is_mapped(logic [7:0] a);
        return (a[1:0] == 2'b00) && (a <= 8'h1C);
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h08, 8'h0C: return m_match[a[3:2]];
            8'h10: return m_cnt;
            8'h14: return {28'd0, m_sts};
            8'h18: return {31'd0, m_wde};
            8'h1C: return {20'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive, let the edge pass, update model, compare
    task automatic step(input bit wr, input bit rd, input logic [7:0] a,
                        input logic [31:0] d, input bit tk, input string tag);
        logic [31:0] exp_rd;
        bit          exp_err;
        bit          exp_rq;
        bit          adv;
        logic [31:0] inc;
        logic [3:0]  hit;
        wr_en = wr; rd_en = rd; addr = a; wdata = d; tick_en = tk;
        exp_rd  = rd ? model_read(a) : 32'd0;
        exp_err = (wr || rd) && !is_mapped(a);
        adv     = tk && !(wr && a == 8'h10);
        inc     = m_cnt + 32'd1;
        for (int n = 0; n < NCH; n++) hit[n] = adv && (inc == m_match[n]);
        exp_rq  = hit[3] && m_wde;
        @(posedge clk);
        if (wr && a == 8'h10) m_cnt = d;
        else if (tk) m_cnt = inc;
        for (int n = 0; n < NCH; n++) begin
            if (hit[n] && m_ien[n]) m_sts[n] = 1'b1;
            else if (wr && a == 8'h14 && d[n]) m_sts[n] = 1'b0;
        end
        if (wr && a[1:0] == 2'b00 && a < 8'h10) m_match[a[3:2]] = d;
        if (wr && a == 8'h1C) m_ien = d[11:0];
        if (hit[3] && m_wde) m_wde = 1'b0;
        else if (wr && a == 8'h18) m_wde = d[0];
        #1;
        chk(irq == m_sts, "R4 irq", {28'd0, irq}, {28'd0, m_sts});
        chk(rst_req == exp_rq, "R9 rst_req", {31'd0, rst_req}, {31'd0, exp_rq});
        chk(err == exp_err, "R10 err", {31'd0, err}, {31'd0, exp_err});
        if (rd) chk(rdata == exp_rd, tag, rdata, exp_rd);
        else chk(rdata == 32'd0, "R11 idle rdata", rdata, 32'd0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, "R11 write");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'd0, 1'b0, tag);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 8'h00, 32'd0, 1'b1, "R2 tick");
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h0051_7EED);
        m_cnt = 0; m_ien = 0; m_sts = 0; m_wde = 0;
        for (int n = 0; n < NCH; n++) m_match[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int w = 0; w < 8; w++) rd(8'(w * 4), "R1 reset read");
        chk(irq == 4'd0, "R1 irq", {28'd0, irq}, 32'd0);
        chk(rst_req == 1'b0, "R1 rst_req", {31'd0, rst_req}, 32'd0);

        // R8: enable register width
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, "R8 ien truncation");
        wr(8'h1C, 32'h0);

        // R2: counting and load priority
        wr(8'h10, 32'd100);
        ticks(5);
        rd(8'h10, "R2 count after ticks");
        step(1'b1, 1'b0, 8'h10, 32'd500, 1'b1, "R2 load with tick");
        rd(8'h10, "R2 load wins over tick");

        // R3: wrap
        wr(8'h10, 32'hFFFF_FFFE);
        ticks(2);
        rd(8'h10, "R3 wrap to zero");

        // R4: enabled match
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd10);
        wr(8'h10, 32'd7);
        ticks(3);
        rd(8'h14, "R4 status set");

        // R5: disabled match
        wr(8'h04, 32'd20);
        wr(8'h10, 32'd18);
        ticks(3);
        rd(8'h14, "R5 disabled channel untouched");

        // R7: write-one clear, set-beats-clear
        wr(8'h14, 32'h2);
        rd(8'h14, "R7 zero-effect clear");
        wr(8'h14, 32'hF);
        rd(8'h14, "R7 clear all");
        wr(8'h00, 32'd50);
        wr(8'h10, 32'd49);
        step(1'b1, 1'b0, 8'h14, 32'h1, 1'b1, "R7 clear with match");
        rd(8'h14, "R7 set wins");
        wr(8'h14, 32'h1);

        // R6: load onto match value
        wr(8'h10, 32'd50);
        rd(8'h14, "R6 load gives no match");

        // R9: watchdog fires once, disarms
        wr(8'h1C, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h0C, 32'd300);
        wr(8'h10, 32'd298);
        ticks(2);
        rd(8'h18, "R9 disarmed");
        wr(8'h10, 32'd298);
        ticks(2);

        // R10: holes and misaligned offsets
        rd(8'h24, "R10 hole read");
        wr(8'h24, 32'hDEAD_BEEF);
        rd(8'h02, "R10 misaligned read");
        wr(8'h11, 32'h1234_5678);
        rd(8'h10, "R10 misaligned write ignored");

        // R11: match readback
        for (int n = 0; n < NCH; n++) wr(8'(n * 4), $urandom);
        for (int n = 0; n < NCH; n++) rd(8'(n * 4), "R11 match readback");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            bit tk;
            op = int'($urandom % 10);
            tk = ($urandom % 4) != 0;
            case (op)
                0: step(1'b1, 1'b0, 8'(($urandom % 4) * 4), m_cnt + ($urandom % 8), tk, "R4 rnd");
                1: step(1'b1, 1'b0, 8'h10, (($urandom % 2) != 0) ? $urandom : m_match[$urandom % 4] - ($urandom % 4), tk, "R2 rnd");
                2: step(1'b1, 1'b0, 8'h14, $urandom, tk, "R7 rnd");
                3: step(1'b1, 1'b0, 8'h1C, $urandom, tk, "R8 rnd");
                4: step(1'b1, 1'b0, 8'h18, $urandom, tk, "R9 rnd");
                5: step(1'b0, 1'b1, 8'($urandom), 32'd0, tk, "R10 rnd read");
                6, 7: step(1'b0, 1'b1, 8'(($urandom % 8) * 4), 32'd0, tk, "R11 rnd read");
                default: step(1'b0, 1'b0, 8'h00, 32'd0, tk, "R2 rnd tick");
            endcase
        end
        finish_run();
    end
endmodule